// File: doc/BRIEF.md
# Multi-Pattern Byte-Wide PRBS Checker

This block checks one 8-bit-per-clock lane against a maximal-length pseudo-random binary sequence. The sequence is one of four, picked by a 2-bit select. For all four polynomials it keeps a 32-bit shift-register state and moves each one eight single-bit steps per clock. The low byte of the selected state is the byte the checker expects to receive next. It compares that byte with the received byte and reports the mismatches as a population count. The count is split by the polarity of the bit that was expected.

The checker needs no external alignment signal. If one byte has more than three bit errors, it raises a relock flag. On the next clock every polynomial state is overwritten with the last four received bytes. This aligns the predictor to the incoming phase. Reset only gives the registers a defined start. An all-zero state never leaves zero, so recovery from any state depends on the relock path.

Top module: `prbs_byte_checker`

## Requirements
- R1: The select `pat_sel` picks the pattern: 0 is the order-7 sequence with feedback taps 6 and 5, 1 is order 15 with taps 14 and 13, 2 is order 23 with taps 22 and 17, and 3 is order 31 with taps 30 and 27. Once locked to a clean stream of the selected pattern, the checker reports no errors and no relock.
- R2: An all-zero predictor state stays zero. After reset, an all-zero input stream produces no errors and no relock.
- R3: Each clock the predictor moves eight steps. Each step shifts the XOR of the two taps in at bit 0. Received bit 7 is the earliest bit of a byte and bit 0 is the latest.
- R4: When relock is high at a clock edge, every predictor state at that edge is loaded with {byte three cycles old, byte two cycles old, byte one cycle old, current byte}, oldest in bits 31:24. After that the checker tracks the stream.
- R5: `err_total` is the number of mismatched bits in a byte, saturated at 7. An all-eight-bit error reads 7, while `ones_err` plus `zeros_err` reads 8.
- R6: `relock` goes high when more than 3 bits of a byte mismatch. Exactly 3 mismatches report a total of 3 and leave `relock` low.
- R7: `ones_err` counts bits expected 1 and received 0. `zeros_err` counts bits expected 0 and received 1.
- R8: A comparison made at a reload edge is discarded. Two clocks after any cycle with `relock` high, both split counts read zero.
- R9: An error in the byte presented in cycle k is first visible on the counts after the edge that ends cycle k+2. The counts are clean after the edge that ends cycle k+1.
- R10: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received lane byte, bit 7 earliest |
| pat_sel | input | 2 | Pattern select (0..3 = order 7, 15, 23, 31) |
| ones_err | output | 4 | Bits expected 1 but received 0 |
| zeros_err | output | 4 | Bits expected 0 but received 1 |
| err_total | output | 3 | Mismatched bits in the byte, saturated at 7 |
| relock | output | 1 | Too many errors; state reload on the next edge |

## Verification
The hardest condition to reach from the ports is a reload that happens while the predictor holds stale or corrupted state. In that case both the discarded comparison and the repeated relock matter. The stimulus reaches it in two ways. It switches the pattern select together with the source pattern while the checker is locked to another polynomial. It also corrupts four bits of one byte, so that the corrupted byte lands inside the 32-bit reload history and causes further relocks. A behavioural model follows every cycle. Directed checks, spaced by the two-clock latency, single out polarity, saturation and the threshold of three.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   localparam int NUM_PAT   = 4;
   localparam int PAT_SEL_W = 2;

   typedef enum logic [PAT_SEL_W-1:0] {
      PAT_O7  = 2'd0,
      PAT_O15 = 2'd1,
      PAT_O23 = 2'd2,
      PAT_O31 = 2'd3
   } pat_e;

   // upper feedback tap of pattern idx
   function automatic int fb_tap_hi(input int idx);
      case (idx)
         0:       return 6;
         1:       return 14;
         2:       return 22;
         default: return 30;
      endcase
   endfunction

   // lower feedback tap of pattern idx
   function automatic int fb_tap_lo(input int idx);
      case (idx)
         0:       return 5;
         1:       return 13;
         2:       return 17;
         default: return 27;
      endcase
   endfunction

endpackage

// File: rtl/prbs_lfsr_lane.sv
module prbs_lfsr_lane #(
   parameter int STATE_W = 32,
   parameter int STEP_N  = 8,
   parameter int TAP_A   = 6,
   parameter int TAP_B   = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               reload,
   input  logic [STATE_W-1:0] load_val,
   output logic [STATE_W-1:0] state
);

   initial begin
      assert (TAP_A < STATE_W && TAP_B < STATE_W)
         else $fatal(1, "feedback tap outside state");
      assert (STEP_N >= 1 && STEP_N <= STATE_W)
         else $fatal(1, "step count out of range");
   end

   logic [STATE_W-1:0] spun;

   // move the register STEP_N single-bit steps in one clock
   always_comb begin
      spun = state;
      for (int i = 0; i < STEP_N; i++) begin
         spun = {spun[STATE_W-2:0], spun[TAP_A] ^ spun[TAP_B]};
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         state <= '0;
      else if (reload) state <= load_val;
      else             state <= spun;
   end

   // R4: a reload takes the received history verbatim
   a_r4_reload_takes_history: assert property (@(posedge clk) disable iff (rst)
      reload |=> state == $past(load_val));

   // R2: zero state is a fixed point of the advance
   a_r2_zero_state_sticks: assert property (@(posedge clk) disable iff (rst)
      (!reload && state == '0) |=> state == '0);

endmodule

// File: rtl/prbs_err_tally.sv
module prbs_err_tally #(
   parameter int LANE_W  = 8,
   parameter int CNT_W   = 3,
   parameter int SPLIT_W = 4,
   parameter int LIMIT   = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [LANE_W-1:0]  mism,
   input  logic [LANE_W-1:0]  expd,
   output logic [SPLIT_W-1:0] ones_cnt,
   output logic [SPLIT_W-1:0] zeros_cnt,
   output logic [CNT_W-1:0]   total,
   output logic               over
);

   localparam int SUM_W   = SPLIT_W + 1;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   initial begin
      assert ((1 << SPLIT_W) > LANE_W) else $fatal(1, "split count too narrow");
      assert (LIMIT < LANE_W) else $fatal(1, "relock limit unreachable");
   end

   logic [SPLIT_W-1:0] ones_c, zeros_c;
   logic [SUM_W-1:0]   sum_c;
   logic [CNT_W-1:0]   tot_c;
   logic               over_c;

   always_comb begin
      ones_c  = '0;
      zeros_c = '0;
      for (int i = 0; i < LANE_W; i++) begin
         ones_c  = ones_c  + SPLIT_W'(mism[i] &  expd[i]);
         zeros_c = zeros_c + SPLIT_W'(mism[i] & ~expd[i]);
      end
      sum_c  = SUM_W'(ones_c) + SUM_W'(zeros_c);
      over_c = sum_c > SUM_W'(LIMIT);
   end

   generate
      if (CNT_MAX >= LANE_W) begin : g_fits
         assign tot_c = CNT_W'(sum_c);
      end else begin : g_saturate
         assign tot_c = (sum_c > SUM_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : CNT_W'(sum_c);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ones_cnt  <= '0;
         zeros_cnt <= '0;
         total     <= '0;
         over      <= 1'b0;
      end else begin
         ones_cnt  <= ones_c;
         zeros_cnt <= zeros_c;
         total     <= tot_c;
         over      <= over_c;
      end
   end

   // R5: total never exceeds the split sum, and saturates
   a_r5_total_within_split: assert property (@(posedge clk) disable iff (rst)
      SUM_W'(total) <= SUM_W'(ones_cnt) + SUM_W'(zeros_cnt));
   a_r5_total_saturates: assert property (@(posedge clk) disable iff (rst)
      (SUM_W'(ones_cnt) + SUM_W'(zeros_cnt) >= SUM_W'(CNT_MAX)) |-> total == CNT_W'(CNT_MAX));

   // R6: relock flag agrees with the reported error counts
   a_r6_flag_needs_errors: assert property (@(posedge clk) disable iff (rst)
      over |-> (SUM_W'(ones_cnt) + SUM_W'(zeros_cnt) > SUM_W'(LIMIT)));
   a_r6_errors_raise_flag: assert property (@(posedge clk) disable iff (rst)
      (SUM_W'(ones_cnt) + SUM_W'(zeros_cnt) > SUM_W'(LIMIT)) |-> over);

endmodule

// File: rtl/prbs_byte_checker.sv
module prbs_byte_checker
   import prbs_chk_pkg::*;
#(
   parameter int LANE_W       = 8,
   parameter int HIST_W       = 32,
   parameter int CNT_W        = 3,
   parameter int RELOCK_LIMIT = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [LANE_W-1:0]            rx_byte,
   input  logic [PAT_SEL_W-1:0]         pat_sel,
   output logic [$clog2(LANE_W+1)-1:0]  ones_err,
   output logic [$clog2(LANE_W+1)-1:0]  zeros_err,
   output logic [CNT_W-1:0]             err_total,
   output logic                         relock
);

   localparam int HIST_DEPTH = HIST_W / LANE_W;
   localparam int SPLIT_W    = $clog2(LANE_W + 1);

   initial begin
      assert (HIST_W % LANE_W == 0) else $fatal(1, "history not whole lanes");
      assert (HIST_DEPTH >= 2) else $fatal(1, "history needs two lanes");
      assert (HIST_W > 30) else $fatal(1, "history shorter than longest tap");
   end

   // received-byte history, stage 0 newest
   logic [HIST_DEPTH-2:0][LANE_W-1:0] hist_q;
   logic [HIST_W-1:0]                 load_val;
   logic [NUM_PAT-1:0][HIST_W-1:0]    lane_state;
   logic [LANE_W-1:0]                 exp_sel;
   logic [LANE_W-1:0]                 mism_q, exp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q <= '0;
      end else begin
         hist_q[0] <= rx_byte;
         for (int s = 1; s < HIST_DEPTH - 1; s++) hist_q[s] <= hist_q[s-1];
      end
   end

   // reload word: oldest byte on top, current byte at the bottom
   assign load_val[LANE_W-1:0] = rx_byte;
   generate
      for (genvar s = 1; s < HIST_DEPTH; s++) begin : g_load
         assign load_val[s*LANE_W +: LANE_W] = hist_q[s-1];
      end
   endgenerate

   generate
      for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
         prbs_lfsr_lane #(
            .STATE_W (HIST_W),
            .STEP_N  (LANE_W),
            .TAP_A   (fb_tap_hi(p)),
            .TAP_B   (fb_tap_lo(p))
         ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .reload   (relock),
            .load_val (load_val),
            .state    (lane_state[p])
         );
      end
   endgenerate

   always_comb exp_sel = lane_state[pat_sel][LANE_W-1:0];

   // compare stage; the compare taken at a reload edge is dropped
   always_ff @(posedge clk) begin
      if (rst) begin
         mism_q <= '0;
         exp_q  <= '0;
      end else if (relock) begin
         mism_q <= '0;
         exp_q  <= '0;
      end else begin
         mism_q <= exp_sel ^ hist_q[0];
         exp_q  <= exp_sel;
      end
   end

   prbs_err_tally #(
      .LANE_W  (LANE_W),
      .CNT_W   (CNT_W),
      .SPLIT_W (SPLIT_W),
      .LIMIT   (RELOCK_LIMIT)
   ) u_tally (
      .clk       (clk),
      .rst       (rst),
      .mism      (mism_q),
      .expd      (exp_q),
      .ones_cnt  (ones_err),
      .zeros_cnt (zeros_err),
      .total     (err_total),
      .over      (relock)
   );

   // R8: counts two clocks after a reload edge carry no errors
   a_r8_reload_compare_dropped: assert property (@(posedge clk) disable iff (rst)
      relock |=> ##1 (ones_err == '0 && zeros_err == '0));

endmodule

// File: tb/tb_prbs_byte_checker.sv
`timescale 1ns/1ps
module tb_prbs_byte_checker;

   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] rx_byte;
   logic [1:0] pat_sel;
   logic [3:0] ones_err, zeros_err;
   logic [2:0] err_total;
   logic       relock;

   always #2 clk = ~clk;   // 250 MHz

   prbs_byte_checker dut (
      .clk       (clk),
      .rst       (rst),
      .rx_byte   (rx_byte),
      .pat_sel   (pat_sel),
      .ones_err  (ones_err),
      .zeros_err (zeros_err),
      .err_total (err_total),
      .relock    (relock)
   );

   int n_chk = 0;
   int n_bad = 0;

   // behavioural reference
   logic [7:0]  rcv_q[$];
   logic [31:0] m_pred[4];
   logic [7:0]  m_mism, m_exp;
   int          m_ones, m_zeros, m_tot;
   bit          m_relock;
   logic [31:0] g_state;

   function automatic int hi_tap(input int p);
      return (p == 0) ? 6 : (p == 1) ? 14 : (p == 2) ? 22 : 30;
   endfunction
   function automatic int lo_tap(input int p);
      return (p == 0) ? 5 : (p == 1) ? 13 : (p == 2) ? 17 : 27;
   endfunction

   function automatic logic [31:0] spin(input logic [31:0] s, input int p, input int n);
      for (int i = 0; i < n; i++) s = {s[30:0], s[hi_tap(p)] ^ s[lo_tap(p)]};
      return s;
   endfunction

   task automatic gen_byte(input int p, output logic [7:0] b);
      for (int j = 7; j >= 0; j--) begin
         g_state = spin(g_state, p, 1);
         b[j] = g_state[0];
      end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      rcv_q = '{8'h0, 8'h0, 8'h0};
      for (int p = 0; p < 4; p++) m_pred[p] = '0;
      m_mism = '0; m_exp = '0;
      m_ones = 0; m_zeros = 0; m_tot = 0; m_relock = 0;
   endtask

   task automatic model_edge(input logic [7:0] b, input int sel);
      int o, z;
      logic [7:0] nm, ne;
      o = $countones(m_mism & m_exp);
      z = $countones(m_mism & ~m_exp);
      if (m_relock) begin
         nm = '0; ne = '0;
      end else begin
         ne = m_pred[sel][7:0];
         nm = ne ^ rcv_q[0];
      end
      for (int p = 0; p < 4; p++)
         m_pred[p] = m_relock ? {rcv_q[2], rcv_q[1], rcv_q[0], b} : spin(m_pred[p], p, 8);
      rcv_q.push_front(b);
      void'(rcv_q.pop_back());
      m_mism   = nm;
      m_exp    = ne;
      m_ones   = o;
      m_zeros  = z;
      m_tot    = (o + z > 7) ? 7 : o + z;
      m_relock = (o + z) > 3;
   endtask

   task automatic step(input logic [7:0] b);
      rx_byte = b;
      @(posedge clk);
      model_edge(b, int'(pat_sel));
      @(negedge clk);
      check(int'(ones_err)  == m_ones,  "R7 ones_err",  ones_err,  m_ones);
      check(int'(zeros_err) == m_zeros, "R7 zeros_err", zeros_err, m_zeros);
      check(int'(err_total) == m_tot,   "R5 err_total", err_total, m_tot);
      check(relock == m_relock,         "R6 relock",    relock,    m_relock);
   endtask

   task automatic clean(input int p, input int n);
      logic [7:0] b;
      repeat (n) begin
         gen_byte(p, b);
         step(b);
      end
   endtask

   // present one corrupted byte (mask over a byte holding both polarities)
   task automatic inject(input int p, input int kind, output logic [7:0] truth);
      logic [7:0] b, m;
      gen_byte(p, b);
      while (b == 8'h00 || b == 8'hFF) begin
         step(b);
         gen_byte(p, b);
      end
      m = '0;
      case (kind)
         0: for (int j = 0; j < 8; j++) if (b[j] && m == 0) m[j] = 1'b1;   // one bit, expected 1
         1: for (int j = 0; j < 8; j++) if (!b[j] && m == 0) m[j] = 1'b1;  // one bit, expected 0
         2: m = 8'h07;
         3: m = 8'h0F;
         default: m = 8'hFF;
      endcase
      truth = b;
      step(b ^ m);
   endtask

   initial begin
      #(4 * 20000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] tb;
      bit seen;
      int errs;
      rst = 1'b1; rx_byte = '0; pat_sel = 2'd0;
      model_reset();
      repeat (4) @(negedge clk);
      // R10: reset state
      check(ones_err == 0,  "R10 ones_err",  ones_err,  0);
      check(zeros_err == 0, "R10 zeros_err", zeros_err, 0);
      check(err_total == 0, "R10 err_total", err_total, 0);
      check(relock == 0,    "R10 relock",    relock,    0);
      rst = 1'b0;

      // R2: zero stream against zero state
      repeat (20) step(8'h00);
      check(relock == 0 && err_total == 0, "R2 zero state holds", err_total, 0);

      // R1 R3 R4: lock to each pattern in turn
      for (int p = 0; p < 4; p++) begin
         pat_sel = 2'(p);
         g_state = 32'h5A3C_96E1;
         seen = 0;
         for (int i = 0; i < 44; i++) begin
            gen_byte(p, tb);
            step(tb);
            if (relock) seen = 1;
         end
         check(seen, "R4 relock on new pattern", seen, 1);
         errs = 0;
         for (int i = 0; i < 16; i++) begin
            gen_byte(p, tb);
            step(tb);
            errs += ones_err + zeros_err + relock;
         end
         check(errs == 0, "R1 R3 locked clean", errs, 0);
      end

      // locked on order 31 now; directed corruptions
      inject(3, 0, tb);
      clean(3, 1);
      check(ones_err == 0 && zeros_err == 0, "R9 not before two edges", ones_err + zeros_err, 0);
      clean(3, 1);
      check(ones_err == 1 && zeros_err == 0, "R7 ones polarity", ones_err, 1);
      clean(3, 40);

      inject(3, 1, tb);
      clean(3, 2);
      check(zeros_err == 1 && ones_err == 0, "R7 zeros polarity", zeros_err, 1);
      check(err_total == 1, "R9 total after two edges", err_total, 1);
      clean(3, 40);

      inject(3, 2, tb);
      clean(3, 2);
      check(err_total == 3, "R6 three errors total", err_total, 3);
      check(relock == 0, "R6 three errors keep lock", relock, 0);
      clean(3, 40);

      inject(3, 4, tb);
      clean(3, 2);
      check(err_total == 7, "R5 saturated total", err_total, 7);
      check(ones_err + zeros_err == 8, "R5 split sum", ones_err + zeros_err, 8);
      check(relock == 1, "R6 eight errors relock", relock, 1);
      clean(3, 60);

      inject(3, 3, tb);
      clean(3, 2);
      check(relock == 1, "R6 four errors relock", relock, 1);
      clean(3, 2);
      check(ones_err == 0 && zeros_err == 0, "R8 reload compare dropped", ones_err + zeros_err, 0);
      clean(3, 80);
      errs = 0;
      for (int i = 0; i < 16; i++) begin
         clean(3, 1);
         errs += ones_err + zeros_err + relock;
      end
      check(errs == 0, "R4 relocked after corrupt history", errs, 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule